// File: doc/BRIEF.md
# Scoreboard Function Unit Handshake Controller

This block is the control wrapper that sits around one execution unit in a scoreboard-style out-of-order core. An instruction enters through a valid/ready issue port that carries an opcode and two source operands. Once the issue is accepted the unit is busy. It asks the register file for its operands and waits for a read grant. That grant freezes the operand and opcode latches and starts the execution unit. When the unit reports a result, the controller keeps it in a holding register and asks for a write slot. The write request is held back while the active-low shadow input is low, and this is the mechanism that lets the core speculate, predicate and raise precise exceptions. A write grant places the held result on the result bus for that one cycle and frees the controller.

The issue port is the only place where back-pressure applies. `issue_ready` is the inverse of `busy`. A transfer happens only in a cycle where both `issue_valid` and `issue_ready` are high and `kill` is low. If `issue_valid` is raised while ready is low, nothing happens: the source does not need to hold it, and it is never queued. The grant inputs come from the scoreboard, and each one is a single-cycle pulse. The execution unit sees a plain start pulse, a done strobe and a cancel line. A kill returns the whole controller to idle.

Top module: `fu_ctl`

## Requirements
- R1: After reset, `busy`, `rd_req`, `wr_req`, `exe_start` and `res_data` are 0, and `issue_ready` is 1. `exe_op` reads all ones, because the opcode is stored inverted in storage that clears to 0.
- R2: In a cycle where `issue_valid` and `issue_ready` are both high and `kill` is low, the issue is accepted. From the next cycle on, `busy` and `rd_req` are 1 and `issue_ready` is 0.
- R3: While `busy` is 1, `issue_valid` has no effect. `busy` stays high, and after the read grant `exe_op`, `exe_src1` and `exe_src2` do not change.
- R4: The operand latch is open from the accepting cycle up to and including the read-grant cycle, whatever the value of `issue_valid`. In each of those cycles, `exe_op`, `exe_src1` and `exe_src2` take the issue-bus values one cycle later. After the grant cycle they hold the values sampled in that cycle.
- R5: In the cycle after a read grant taken while `rd_req` is high, `rd_req` is 0 and `exe_start` is 1. `exe_start` is high for exactly that one cycle.
- R6: In the cycle after `exe_done` is seen while executing, `exe_result` has been captured and `wr_req` is 1, provided `shadow_n` is 1. `wr_req` is only ever high while `busy` is 1 and `rd_req` is 0.
- R7: While a result is pending, `wr_req` follows `shadow_n` in the same cycle. It is 0 whenever `shadow_n` is 0 and 1 again as soon as `shadow_n` returns to 1.
- R8: In a cycle where `wr_grant` and `wr_req` are both high, `res_data` equals the captured result, combinationally. In every other cycle `res_data` is 0.
- R9: In the cycle after a write grant, `busy` and `wr_req` are 0 and `issue_ready` is 1.
- R10: `kill` drives `exe_cancel` high in the same cycle. It overrides every other input. In the next cycle `busy`, `rd_req`, `wr_req` and `exe_start` are 0, and `exe_op` reads all ones again.
- R11: `rd_grant` and `wr_grant` are never high in the same cycle. This is an input rule that the scoreboard must obey.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| kill | input | 1 | Cancel everything and return to idle |
| issue_valid | input | 1 | Issue port valid |
| issue_ready | output | 1 | Issue port ready (inverse of busy) |
| issue_op | input | OPW | Opcode on the issue bus |
| issue_src1 | input | DW | First source operand bus |
| issue_src2 | input | DW | Second source operand bus |
| busy | output | 1 | Controller holds an instruction |
| rd_req | output | 1 | Register read request |
| rd_grant | input | 1 | One-cycle register read grant |
| exe_start | output | 1 | One-cycle start pulse to the execution unit |
| exe_cancel | output | 1 | Cancel to the execution unit |
| exe_op | output | OPW | Latched opcode |
| exe_src1 | output | DW | Latched first operand |
| exe_src2 | output | DW | Latched second operand |
| exe_done | input | 1 | Execution unit result strobe |
| exe_result | input | DW | Execution unit result |
| shadow_n | input | 1 | Active-low hold on the write request |
| wr_req | output | 1 | Register write request |
| wr_grant | input | 1 | One-cycle register write grant |
| res_data | output | DW | Result bus, valid only in the write-grant cycle |

## Verification
Registered responses are due one edge after their cause: busy and the read request after an accepted issue, the start pulse and the dropped read request after a read grant, the write request after a done strobe, release after a write grant, and idle after a kill. Combinational responses are due in the same cycle: the write request following the shadow input, the result bus during a grant, and the cancel line during a kill. The bench changes its inputs just after a rising edge and samples at the following falling edge. A registered result is therefore read in the first falling edge after the edge that causes it, and a combinational result is read in the same half-cycle as its stimulus. Random operand values, grant delays, execution latencies and shadow-hold lengths vary these windows without moving the cycle in which each result is due.

// File: rtl/fu_ctl_pkg.sv
package fu_ctl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RDWAIT = 2'd1,
    ST_EXEC   = 2'd2,
    ST_WRWAIT = 2'd3
  } fu_state_e;
endpackage

// File: rtl/fu_ctl_seq.sv
module fu_ctl_seq
  import fu_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic issue_valid,
  input  logic rd_grant,
  input  logic exe_done,
  input  logic shadow_n,
  input  logic wr_grant,
  output logic busy,
  output logic rd_req,
  output logic wr_req,
  output logic exe_start,
  output logic accept,
  output logic capture,
  output logic wr_fire
);
  fu_state_e state_q, state_d;
  logic      start_q;
  logic      rd_fire;

  assign busy      = (state_q != ST_IDLE);
  assign rd_req    = (state_q == ST_RDWAIT);
  // a pending write is released only while the shadow hold is off
  assign wr_req    = (state_q == ST_WRWAIT) && shadow_n;
  assign accept    = issue_valid && !busy && !kill;
  assign rd_fire   = rd_req && rd_grant && !kill;
  assign capture   = (state_q == ST_EXEC) && exe_done && !kill;
  assign wr_fire   = wr_req && wr_grant && !kill;
  assign exe_start = start_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept)  state_d = ST_RDWAIT;
      ST_RDWAIT: if (rd_fire) state_d = ST_EXEC;
      ST_EXEC:   if (capture) state_d = ST_WRWAIT;
      ST_WRWAIT: if (wr_fire) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
    if (kill) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= rd_fire;
    end
  end
endmodule

// File: rtl/fu_ctl_oplatch.sv
module fu_ctl_oplatch #(
  parameter int OPW  = 4,
  parameter int DW   = 16,
  parameter int NSRC = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      open_gate,
  input  logic [OPW-1:0]            op_in,
  input  logic [NSRC-1:0][DW-1:0]   src_in,
  output logic [OPW-1:0]            op_out,
  output logic [NSRC-1:0][DW-1:0]   src_out
);
  // opcode kept inverted so the cleared storage reads back as all ones
  logic [OPW-1:0] op_inv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         op_inv_q <= '0;
    else if (clear)     op_inv_q <= '0;
    else if (open_gate) op_inv_q <= ~op_in;
  end
  assign op_out = ~op_inv_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic [DW-1:0] val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         val_q <= '0;
      else if (clear)     val_q <= '0;
      else if (open_gate) val_q <= src_in[g];
    end
    assign src_out[g] = val_q;
  end
endmodule

// File: rtl/fu_ctl_result.sv
module fu_ctl_result #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          capture,
  input  logic [DW-1:0] result_in,
  input  logic          drive,
  output logic [DW-1:0] res_data
);
  logic [DW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (clear)   hold_q <= '0;
    else if (capture) hold_q <= result_in;
  end

  assign res_data = drive ? hold_q : '0;
endmodule

// File: rtl/fu_ctl.sv
module fu_ctl #(
  parameter int OPW = 4,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           kill,
  input  logic           issue_valid,
  output logic           issue_ready,
  input  logic [OPW-1:0] issue_op,
  input  logic [DW-1:0]  issue_src1,
  input  logic [DW-1:0]  issue_src2,
  output logic           busy,
  output logic           rd_req,
  input  logic           rd_grant,
  output logic           exe_start,
  output logic           exe_cancel,
  output logic [OPW-1:0] exe_op,
  output logic [DW-1:0]  exe_src1,
  output logic [DW-1:0]  exe_src2,
  input  logic           exe_done,
  input  logic [DW-1:0]  exe_result,
  input  logic           shadow_n,
  output logic           wr_req,
  input  logic           wr_grant,
  output logic [DW-1:0]  res_data
);
  localparam int NSRC = 2;

  logic                    accept, capture, wr_fire;
  logic [NSRC-1:0][DW-1:0] src_bus, src_lat;

  fu_ctl_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .kill       (kill),
    .issue_valid(issue_valid),
    .rd_grant   (rd_grant),
    .exe_done   (exe_done),
    .shadow_n   (shadow_n),
    .wr_grant   (wr_grant),
    .busy       (busy),
    .rd_req     (rd_req),
    .wr_req     (wr_req),
    .exe_start  (exe_start),
    .accept     (accept),
    .capture    (capture),
    .wr_fire    (wr_fire)
  );

  assign src_bus = {issue_src2, issue_src1};

  fu_ctl_oplatch #(.OPW(OPW), .DW(DW), .NSRC(NSRC)) u_lat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (kill),
    .open_gate(accept || rd_req),
    .op_in    (issue_op),
    .src_in   (src_bus),
    .op_out   (exe_op),
    .src_out  (src_lat)
  );

  assign exe_src1 = src_lat[0];
  assign exe_src2 = src_lat[1];

  fu_ctl_result #(.DW(DW)) u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (kill),
    .capture  (capture),
    .result_in(exe_result),
    .drive    (wr_fire),
    .res_data (res_data)
  );

  assign issue_ready = !busy;
  assign exe_cancel  = kill;
endmodule

// File: rtl/fu_ctl_chk.sv
module fu_ctl_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          kill,
  input logic          issue_valid,
  input logic          issue_ready,
  input logic          busy,
  input logic          rd_req,
  input logic          rd_grant,
  input logic          exe_start,
  input logic          wr_req,
  input logic          wr_grant,
  input logic [DW-1:0] res_data
);
  p_grant_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_grant && wr_grant));

  p_issue_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready && !kill) |=> (busy && rd_req && !issue_ready));

  p_rd_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_grant && rd_req && !kill) |=> (!rd_req && exe_start));

  p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exe_start |=> !exe_start);

  p_wr_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (busy && !rd_req));

  p_res_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_grant && wr_req) |-> (res_data == '0));

  p_wr_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_grant && wr_req && !kill) |=> (!busy && !wr_req && issue_ready));

  p_kill_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!busy && !rd_req && !wr_req && !exe_start));
endmodule

bind fu_ctl fu_ctl_chk #(.DW(DW)) u_chk (.*);

// File: tb/fu_ctl_tb.sv
`timescale 1ns/100ps
module fu_ctl_tb;
  localparam int OPW = 4;
  localparam int DW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kill = 1'b0, issue_valid = 1'b0, rd_grant = 1'b0, exe_done = 1'b0;
  logic shadow_n = 1'b1, wr_grant = 1'b0;
  logic [OPW-1:0] issue_op = '0;
  logic [DW-1:0]  issue_src1 = '0, issue_src2 = '0, exe_result = '0;
  logic issue_ready, busy, rd_req, exe_start, exe_cancel, wr_req;
  logic [OPW-1:0] exe_op;
  logic [DW-1:0]  exe_src1, exe_src2, res_data;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fu_ctl #(.OPW(OPW), .DW(DW)) u_dut (.*);

  function automatic logic [DW-1:0] exp_res_bus(input logic granted, input logic [DW-1:0] held);
    return granted ? held : '0;
  endfunction

  function automatic logic [OPW-1:0] exp_idle_op();
    return {OPW{1'b1}};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic smp();
    @(negedge clk);
  endtask

  task automatic run_txn(input int rd_dly, input int ex_dly, input int sh_len);
    logic [OPW-1:0] op_f;
    logic [DW-1:0]  s1_f, s2_f, res;
    issue_valid = 1'b1;
    issue_op = OPW'($urandom); issue_src1 = DW'($urandom); issue_src2 = DW'($urandom);
    op_f = issue_op; s1_f = issue_src1; s2_f = issue_src2;
    cyc(); issue_valid = 1'b0;
    smp();
    chk("R2 busy", busy, 1); chk("R2 rd_req", rd_req, 1); chk("R2 ready", issue_ready, 0);
    chk("R4 src1 open", exe_src1, s1_f);
    for (int i = 0; i < rd_dly; i++) begin
      cyc();
      issue_valid = i[0];
      issue_op = OPW'($urandom); issue_src1 = DW'($urandom); issue_src2 = DW'($urandom);
      op_f = issue_op; s1_f = issue_src1; s2_f = issue_src2;
      smp(); chk("R3 busy held", busy, 1);
    end
    cyc();
    rd_grant = 1'b1; issue_valid = 1'b1;
    issue_op = OPW'($urandom); issue_src1 = DW'($urandom); issue_src2 = DW'($urandom);
    op_f = issue_op; s1_f = issue_src1; s2_f = issue_src2;
    cyc();
    rd_grant = 1'b0;
    issue_op = ~op_f; issue_src1 = ~s1_f; issue_src2 = ~s2_f;
    smp();
    chk("R5 rd_req drop", rd_req, 0); chk("R5 start", exe_start, 1);
    chk("R4 op held", exe_op, op_f); chk("R4 src1 held", exe_src1, s1_f);
    chk("R4 src2 held", exe_src2, s2_f);
    for (int i = 0; i < ex_dly; i++) begin
      cyc(); issue_src1 = DW'($urandom);
      smp(); chk("R5 start one cycle", exe_start, 0);
      chk("R3 src1 stable", exe_src1, s1_f); chk("R3 busy", busy, 1);
    end
    issue_valid = 1'b0;
    cyc();
    res = DW'($urandom);
    exe_done = 1'b1; exe_result = res;
    if (sh_len > 0) shadow_n = 1'b0;
    cyc();
    exe_done = 1'b0; exe_result = ~res;
    for (int i = 0; i < sh_len; i++) begin
      smp(); chk("R7 held by shadow", wr_req, 0); chk("R7 busy", busy, 1);
      cyc();
    end
    shadow_n = 1'b1;
    smp(); chk("R6 wr_req", wr_req, 1); chk("R8 bus quiet", res_data, exp_res_bus(1'b0, res));
    cyc(); wr_grant = 1'b1;
    smp(); chk("R8 result bus", res_data, exp_res_bus(1'b1, res));
    cyc(); wr_grant = 1'b0;
    smp();
    chk("R9 busy", busy, 0); chk("R9 wr_req", wr_req, 0); chk("R9 ready", issue_ready, 1);
    chk("R8 bus after", res_data, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    #12 smp();
    chk("R1 busy", busy, 0); chk("R1 rd_req", rd_req, 0); chk("R1 wr_req", wr_req, 0);
    chk("R1 ready", issue_ready, 1); chk("R1 op", exe_op, exp_idle_op());
    chk("R1 res", res_data, 0); chk("R1 start", exe_start, 0);
    cyc(); rst_n = 1'b1;
    cyc();
    // R11: grants are only ever driven one at a time below
    run_txn(0, 0, 0);
    run_txn(3, 2, 4);
    run_txn(1, 0, 1);
    for (int t = 0; t < 20; t++)
      run_txn(int'($urandom % 5), int'($urandom % 4), int'($urandom % 4));
    // R7 shadow toggling while pending
    issue_valid = 1'b1; cyc(); issue_valid = 1'b0;
    cyc(); rd_grant = 1'b1; cyc(); rd_grant = 1'b0;
    exe_done = 1'b1; exe_result = 16'h5a5a; cyc(); exe_done = 1'b0;
    smp(); chk("R6 wr_req up", wr_req, 1);
    cyc(); shadow_n = 1'b0; smp(); chk("R7 drop same cycle", wr_req, 0);
    cyc(); shadow_n = 1'b1; smp(); chk("R7 return same cycle", wr_req, 1);
    // R10 kill while a write is pending
    cyc(); kill = 1'b1; smp(); chk("R10 cancel", exe_cancel, 1);
    cyc(); kill = 1'b0; smp();
    chk("R10 busy", busy, 0); chk("R10 wr_req", wr_req, 0);
    // R10 kill during execution restores opcode
    issue_valid = 1'b1; issue_op = 4'h3; cyc(); issue_valid = 1'b0;
    rd_grant = 1'b1; cyc(); rd_grant = 1'b0;
    smp(); chk("R4 op latched", exe_op, 4'h3);
    cyc(); kill = 1'b1; cyc(); kill = 1'b0;
    smp(); chk("R10 op reset", exe_op, exp_idle_op()); chk("R10 start", exe_start, 0);
    // R10 kill beats a simultaneous issue
    issue_valid = 1'b1; kill = 1'b1; cyc(); issue_valid = 1'b0; kill = 1'b0;
    smp(); chk("R10 kill priority busy", busy, 0); chk("R10 kill priority rd", rd_req, 0);
    smp(); chk("R10 cancel low", exe_cancel, 0);
    // R10 kill in read wait
    issue_valid = 1'b1; cyc(); issue_valid = 1'b0; kill = 1'b1;
    cyc(); kill = 1'b0; smp(); chk("R10 rd_req cleared", rd_req, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule